// File: doc/BRIEF.md
# Speculative Store Buffer with Load Forwarding

This block holds the data of executed stores until each one is known to be architecturally real, so that no speculative store ever reaches memory. Every slot is free, speculative, or committed-and-waiting-to-drain. A store that executes takes a free slot in the speculative state and records its instruction tag, word address and data. A commit, naming the store by tag, moves that slot to the committed state. An abort, also by tag, releases a speculative slot. A flush releases every speculative slot at once and leaves committed slots in place.

Committed slots are written to the data cache through a valid/ready drain port, one per cycle and oldest first. A slot is released only in the cycle the cache accepts it. Loads probe the buffer with a word address and their own instruction tag. The buffer answers in the same cycle with a hit flag and the data of the youngest buffered store that is older than the load and has the same address. On a hit the caller uses this data instead of the cache data.

Instruction tags come from a circular sequence and are compared in a wrap-aware way. When every slot is occupied the buffer raises a full flag so that store execution stalls.

Top module: `ssb_store_buffer`

## Requirements
- R1: A store presented with `st_en` while `full` is low occupies a slot in the speculative state, holding its tag, address and data. From the next cycle on it is visible to load lookups.
- R2: A speculative slot is never offered on the drain port, so `dr_valid` stays low while no slot is committed.
- R3: `cm_en` with `cm_tag` equal to a speculative slot's tag makes that slot committed, and from the next cycle it is eligible to drain.
- R4: `ab_en` with `ab_tag` equal to a speculative slot's tag frees that slot, and later loads no longer see it. An abort whose tag names a committed slot has no effect.
- R5: `flush` frees every speculative slot in one cycle and keeps every committed slot that has not yet drained.
- R6: The drain port offers the oldest committed slot (by tag age) with its address and data, holds it unchanged while `dr_ready` is low, and frees it in the cycle that `dr_valid` and `dr_ready` are both high. At most one slot drains per cycle.
- R7: `fwd_hit` is high when some occupied slot has an address equal to `ld_addr` and a tag older than `ld_tag`. `fwd_data` then carries the data of the youngest such slot. Slots with a younger tag or a different address are ignored. On a miss `fwd_data` is zero. The lookup sees only slots occupied before the current clock edge.
- R8: Tag a is older than tag b when (a - b) modulo 2^TAG_W has its top bit set. This is correct while all live tags lie within half the tag range. For TAG_W = 6, tag 62 is older than tag 1, and tag 1 is older than tag 2.
- R9: `full` is high exactly when all DEPTH (8) slots are occupied. A store presented while `full` is high is dropped.
- R10: In a cycle with `flush` high, the same-cycle store, commit and abort inputs are ignored. The drain handshake still takes effect in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; all slots free |
| st_en | input | 1 | Store execute write |
| st_tag | input | TAG_W | Instruction tag of the executing store |
| st_addr | input | ADDR_W | Word address of the store |
| st_data | input | DATA_W | Store data |
| full | output | 1 | All slots occupied; stall store execution |
| cm_en | input | 1 | Commit a store |
| cm_tag | input | TAG_W | Tag of the committing store |
| ab_en | input | 1 | Abort a speculative store |
| ab_tag | input | TAG_W | Tag of the aborted store |
| flush | input | 1 | Free all speculative slots |
| ld_addr | input | ADDR_W | Word address of the probing load |
| ld_tag | input | TAG_W | Instruction tag of the probing load |
| fwd_hit | output | 1 | A buffered older store matches the load |
| fwd_data | output | DATA_W | Forwarded store data, zero on a miss |
| dr_valid | output | 1 | A committed slot is offered to the cache |
| dr_addr | output | ADDR_W | Word address of the offered slot |
| dr_data | output | DATA_W | Data of the offered slot |
| dr_ready | input | 1 | Cache accepts the offered write |

## Verification
Slot state is mostly hidden, so a wrong state shows up at the ports only when something probes it. A slot wrongly left speculative keeps `dr_valid` low in the cycle after its commit. A slot wrongly freed turns a later load hit into a miss, and that is visible as soon as a load names its address. A wrong age decision shows as forwarded data from the wrong store, or as a drain out of tag order, in the first cycle that both candidates are live. Comparing `full`, the drain port and the forwarding outputs against a behavioural model on every cycle therefore catches a corrupted slot within the cycle in which it next matters.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    // Life cycle of one buffer slot
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_SPEC = 2'd1,
        SLOT_DONE = 2'd2
    } slot_st_e;
endpackage

// File: rtl/ssb_free_find.sv
// Lowest-index free slot finder.
module ssb_free_find #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     free_vec,
    output logic             any_free,
    output logic [IDX_W-1:0] idx
);
    timeunit 1ns;
    timeprecision 100ps;

    always_comb begin
        any_free = |free_vec;
        idx      = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/ssb_age_pick.sv
// Picks the youngest (PICK_YOUNG=1) or oldest candidate by wrap-aware tag age.
module ssb_age_pick #(
    parameter int N          = 8,
    parameter int TAG_W      = 6,
    parameter int IDX_W      = 3,
    parameter bit PICK_YOUNG = 1'b1
) (
    input  logic [N-1:0]            cand,
    input  logic [N-1:0][TAG_W-1:0] tags,
    output logic                    found,
    output logic [IDX_W-1:0]        idx
);
    timeunit 1ns;
    timeprecision 100ps;

    function automatic logic older(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b);
        logic [TAG_W-1:0] diff;
        diff = a - b;
        return diff[TAG_W-1];
    endfunction

    // beat[i][j]: candidate i is preferred over candidate j
    logic [N-1:0] beat [N];
    logic [N-1:0] win;

    for (genvar gi = 0; gi < N; gi++) begin : g_row
        for (genvar gj = 0; gj < N; gj++) begin : g_col
            if (gi == gj) begin : g_diag
                assign beat[gi][gj] = 1'b1;
            end else if (PICK_YOUNG) begin : g_young
                assign beat[gi][gj] = older(tags[gj], tags[gi]);
            end else begin : g_old
                assign beat[gi][gj] = older(tags[gi], tags[gj]);
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            win[i] = cand[i] && ((beat[i] | ~cand) == {N{1'b1}});
        end
        found = |win;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (win[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/ssb_store_buffer.sv
module ssb_store_buffer #(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 6,
    parameter int ADDR_W = 30,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_en,
    input  logic [TAG_W-1:0]  st_tag,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    output logic              full,
    input  logic              cm_en,
    input  logic [TAG_W-1:0]  cm_tag,
    input  logic              ab_en,
    input  logic [TAG_W-1:0]  ab_tag,
    input  logic              flush,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [TAG_W-1:0]  ld_tag,
    output logic              fwd_hit,
    output logic [DATA_W-1:0] fwd_data,
    output logic              dr_valid,
    output logic [ADDR_W-1:0] dr_addr,
    output logic [DATA_W-1:0] dr_data,
    input  logic              dr_ready
);
    timeunit 1ns;
    timeprecision 100ps;
    import ssb_pkg::*;

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct {
        slot_st_e          st   [DEPTH];
        logic [TAG_W-1:0]  tag  [DEPTH];
        logic [ADDR_W-1:0] addr [DEPTH];
        logic [DATA_W-1:0] data [DEPTH];
    } sb_state_t;

    sb_state_t state_d, state_q;

    function automatic logic older(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b);
        logic [TAG_W-1:0] diff;
        diff = a - b;
        return diff[TAG_W-1];
    endfunction

    logic [DEPTH-1:0]            free_vec, done_vec, hit_vec, occ_vec;
    logic [DEPTH-1:0][TAG_W-1:0] tag_vec;
    logic                        alloc_any, fwd_found, drn_found, drain_fire;
    logic [IDX_W-1:0]            alloc_idx, fwd_idx, drn_idx;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            free_vec[i] = (state_q.st[i] == SLOT_FREE);
            done_vec[i] = (state_q.st[i] == SLOT_DONE);
            occ_vec[i]  = !free_vec[i];
            hit_vec[i]  = occ_vec[i] && (state_q.addr[i] == ld_addr)
                          && older(state_q.tag[i], ld_tag);
            tag_vec[i]  = state_q.tag[i];
        end
    end

    ssb_free_find #(.N(DEPTH), .IDX_W(IDX_W)) u_alloc (
        .free_vec (free_vec),
        .any_free (alloc_any),
        .idx      (alloc_idx)
    );

    ssb_age_pick #(.N(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W), .PICK_YOUNG(1'b1)) u_fwd_pick (
        .cand  (hit_vec),
        .tags  (tag_vec),
        .found (fwd_found),
        .idx   (fwd_idx)
    );

    ssb_age_pick #(.N(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W), .PICK_YOUNG(1'b0)) u_drain_pick (
        .cand  (done_vec),
        .tags  (tag_vec),
        .found (drn_found),
        .idx   (drn_idx)
    );

    assign full       = !alloc_any;
    assign fwd_hit    = fwd_found;
    assign fwd_data   = fwd_found ? state_q.data[fwd_idx] : '0;
    assign dr_valid   = drn_found;
    assign dr_addr    = drn_found ? state_q.addr[drn_idx] : '0;
    assign dr_data    = drn_found ? state_q.data[drn_idx] : '0;
    assign drain_fire = drn_found && dr_ready;

    // Next-state computation
    always_comb begin
        state_d = state_q;
        if (drain_fire) state_d.st[drn_idx] = SLOT_FREE;
        if (flush) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (state_q.st[i] == SLOT_SPEC) state_d.st[i] = SLOT_FREE;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (state_q.st[i] == SLOT_SPEC) begin
                    if (cm_en && state_q.tag[i] == cm_tag)      state_d.st[i] = SLOT_DONE;
                    else if (ab_en && state_q.tag[i] == ab_tag) state_d.st[i] = SLOT_FREE;
                end
            end
            if (st_en && alloc_any) begin
                state_d.st[alloc_idx]   = SLOT_SPEC;
                state_d.tag[alloc_idx]  = st_tag;
                state_d.addr[alloc_idx] = st_addr;
                state_d.data[alloc_idx] = st_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                state_q.st[i]   <= SLOT_FREE;
                state_q.tag[i]  <= '0;
                state_q.addr[i] <= '0;
                state_q.data[i] <= '0;
            end
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- assertions ----------------
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot_chk
        a_r3_commit_moves: assert property (@(posedge clk) disable iff (!rst_n)
            (cm_en && !flush && state_q.st[gi] == SLOT_SPEC && state_q.tag[gi] == cm_tag)
            |=> (state_q.st[gi] == SLOT_DONE));
        a_r4_abort_frees: assert property (@(posedge clk) disable iff (!rst_n)
            (ab_en && !flush && !(cm_en && cm_tag == ab_tag)
             && state_q.st[gi] == SLOT_SPEC && state_q.tag[gi] == ab_tag)
            |=> (state_q.st[gi] == SLOT_FREE));
    end

    a_r1_store_takes_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en && !full && !flush && !drain_fire && !ab_en)
        |=> ($countones(occ_vec) == $past($countones(occ_vec)) + 1));

    a_r6_drain_held: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_valid && !dr_ready)
        |=> (dr_valid && $stable(dr_addr) && $stable(dr_data)));

    a_r9_full_drops_store: assert property (@(posedge clk) disable iff (!rst_n)
        (full && st_en && !drain_fire)
        |=> ($countones(occ_vec) <= $past($countones(occ_vec))));

    a_r10_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ($countones(occ_vec) <= $past($countones(done_vec))));
endmodule

// File: tb/ssb_store_buffer_tb_top.sv
module ssb_store_buffer_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DEPTH  = 8;
    localparam int TAG_W  = 6;
    localparam int ADDR_W = 30;
    localparam int DATA_W = 32;
    localparam int TMASK  = (1 << TAG_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              st_en, cm_en, ab_en, flush, dr_ready;
    logic [TAG_W-1:0]  st_tag, cm_tag, ab_tag, ld_tag;
    logic [ADDR_W-1:0] st_addr, ld_addr;
    logic [DATA_W-1:0] st_data;
    logic              full, fwd_hit, dr_valid;
    logic [DATA_W-1:0] fwd_data, dr_data;
    logic [ADDR_W-1:0] dr_addr;

    ssb_store_buffer #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .st_en(st_en), .st_tag(st_tag), .st_addr(st_addr), .st_data(st_data), .full(full),
        .cm_en(cm_en), .cm_tag(cm_tag), .ab_en(ab_en), .ab_tag(ab_tag), .flush(flush),
        .ld_addr(ld_addr), .ld_tag(ld_tag), .fwd_hit(fwd_hit), .fwd_data(fwd_data),
        .dr_valid(dr_valid), .dr_addr(dr_addr), .dr_data(dr_data), .dr_ready(dr_ready)
    );

    always #4 clk = ~clk;

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 1'b0;

    // ---------------- behavioural reference ----------------
    typedef struct {
        int          tag;
        int unsigned addr;
        int unsigned data;
        bit          cmt;
    } ent_t;
    ent_t mdl[$];

    function automatic bit is_older(int a, int b);  // R8 rule
        return (((a - b) & TMASK) >= (1 << (TAG_W - 1)));
    endfunction

    function automatic int fwd_pick();
        int best = -1;
        for (int k = 0; k < mdl.size(); k++) begin
            if (mdl[k].addr == int'(ld_addr) && is_older(mdl[k].tag, int'(ld_tag))) begin
                if (best < 0 || is_older(mdl[best].tag, mdl[k].tag)) best = k;
            end
        end
        return best;
    endfunction

    function automatic int drain_pick();
        int best = -1;
        for (int k = 0; k < mdl.size(); k++) begin
            if (mdl[k].cmt && (best < 0 || is_older(mdl[k].tag, mdl[best].tag))) best = k;
        end
        return best;
    endfunction

    task automatic cmp(string req, string what, longint act, longint exp);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk(string req, string what, longint act, longint exp);
        vectors++;
        cmp(req, what, act, exp);
    endtask

    task automatic compare_model();
        int fi = fwd_pick();
        int di = drain_pick();
        vectors++;
        cmp("R9", "full", full, mdl.size() == DEPTH);
        cmp("R6", "dr_valid", dr_valid, di >= 0);
        if (di >= 0) begin
            cmp("R6", "dr_addr", dr_addr, mdl[di].addr);
            cmp("R6", "dr_data", dr_data, mdl[di].data);
        end
        cmp("R7", "fwd_hit", fwd_hit, fi >= 0);
        cmp("R7", "fwd_data", fwd_data, (fi >= 0) ? mdl[fi].data : 0);
    endtask

    task automatic update_model();
        int di = drain_pick();
        int pre = mdl.size();
        if (di >= 0 && dr_ready) mdl.delete(di);
        if (flush) begin
            for (int k = mdl.size() - 1; k >= 0; k--) if (!mdl[k].cmt) mdl.delete(k);
        end else begin
            for (int k = mdl.size() - 1; k >= 0; k--) begin
                if (!mdl[k].cmt && cm_en && mdl[k].tag == int'(cm_tag)) mdl[k].cmt = 1'b1;
                else if (!mdl[k].cmt && ab_en && mdl[k].tag == int'(ab_tag)) mdl.delete(k);
            end
            if (st_en && pre < DEPTH) begin
                ent_t e;
                e.tag = int'(st_tag); e.addr = st_addr; e.data = st_data; e.cmt = 1'b0;
                mdl.push_back(e);
            end
        end
    endtask

    // Called shortly after a falling edge with inputs driven
    task automatic cycle();
        #0.5;
        compare_model();
        @(posedge clk);
        if (rst_n) update_model();
        @(negedge clk);
        st_en = 0; cm_en = 0; ab_en = 0; flush = 0;
    endtask

    task automatic ld(int a, int t);
        ld_addr = ADDR_W'(a); ld_tag = TAG_W'(t);
        #0.2;
    endtask

    task automatic do_store(int t, int a, int unsigned d);
        st_en = 1; st_tag = TAG_W'(t); st_addr = ADDR_W'(a); st_data = d;
        cycle();
    endtask

    task automatic do_commit(int t);
        cm_en = 1; cm_tag = TAG_W'(t);
        cycle();
    endtask

    task automatic do_abort(int t);
        ab_en = 1; ab_tag = TAG_W'(t);
        cycle();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #1600000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int next_tag;
        rst_n = 0; st_en = 0; cm_en = 0; ab_en = 0; flush = 0; dr_ready = 0;
        st_tag = '0; st_addr = '0; st_data = '0; cm_tag = '0; ab_tag = '0;
        ld_addr = '0; ld_tag = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // reset state
        ld(32'h10, 6);
        chk("R7", "reset fwd_hit", fwd_hit, 0);
        chk("R9", "reset full", full, 0);
        chk("R2", "reset dr_valid", dr_valid, 0);
        cycle();

        // R1: store becomes visible next cycle, R2: not drained while speculative
        do_store(5, 32'h10, 32'hAAAA_0001);
        ld(32'h10, 6);
        chk("R1", "fwd_hit", fwd_hit, 1);
        chk("R1", "fwd_data", fwd_data, 32'hAAAA_0001);
        chk("R2", "dr_valid spec", dr_valid, 0);
        ld(32'h10, 4);
        chk("R7", "younger store ignored", fwd_hit, 0);
        ld(32'h11, 6);
        chk("R7", "other address ignored", fwd_hit, 0);
        do_store(7, 32'h10, 32'hBBBB_0002);
        ld(32'h10, 9);
        chk("R7", "youngest older store", fwd_data, 32'hBBBB_0002);
        ld(32'h10, 6);
        chk("R7", "skip younger of two", fwd_data, 32'hAAAA_0001);
        cycle();

        // R3: commit makes slot drainable; R6 hold while not ready
        do_commit(5);
        chk("R3", "dr_valid after commit", dr_valid, 1);
        chk("R3", "dr_data after commit", dr_data, 32'hAAAA_0001);
        chk("R3", "dr_addr after commit", dr_addr, 32'h10);
        cycle();
        chk("R6", "held data", dr_data, 32'hAAAA_0001);

        // R4: abort frees speculative slot, not a committed one
        do_abort(7);
        ld(32'h10, 9);
        chk("R4", "aborted store gone", fwd_data, 32'hAAAA_0001);
        do_abort(5);
        chk("R4", "committed survives abort", dr_valid, 1);

        // R6: accept frees the slot
        dr_ready = 1;
        cycle();
        dr_ready = 0;
        chk("R6", "dr_valid after accept", dr_valid, 0);
        ld(32'h10, 9);
        chk("R6", "drained slot freed", fwd_hit, 0);

        // R5: flush keeps committed, drops speculative
        do_store(10, 32'h20, 32'hC1C1_0010);
        do_store(11, 32'h20, 32'hC2C2_0011);
        do_commit(10);
        flush = 1;
        cycle();
        ld(32'h20, 12);
        chk("R5", "speculative flushed", fwd_data, 32'hC1C1_0010);
        chk("R5", "committed kept", dr_data, 32'hC1C1_0010);
        dr_ready = 1;
        cycle();
        dr_ready = 0;

        // R9: full and dropped store
        for (int k = 0; k < DEPTH; k++) do_store(12 + k, 32'h30 + k, 32'h3000 + k);
        chk("R9", "full at depth", full, 1);
        do_store(20, 32'h50, 32'h5555_5555);
        ld(32'h50, 21);
        chk("R9", "store while full dropped", fwd_hit, 0);
        flush = 1;
        cycle();
        chk("R9", "full after flush", full, 0);

        // R8: wrap-aware ages
        do_store(62, 32'h40, 32'hD1D1_0062);
        do_store(1, 32'h40, 32'hD2D2_0001);
        ld(32'h40, 0);
        chk("R8", "wrap: 62 older than 0", fwd_data, 32'hD1D1_0062);
        ld(32'h40, 2);
        chk("R8", "wrap: 1 youngest older", fwd_data, 32'hD2D2_0001);
        ld(32'h40, 63);
        chk("R8", "wrap: 1 younger than 63", fwd_data, 32'hD1D1_0062);
        do_commit(62);
        do_commit(1);
        chk("R6", "oldest drains first", dr_data, 32'hD1D1_0062);
        dr_ready = 1;
        cycle();
        chk("R6", "second in order", dr_data, 32'hD2D2_0001);
        cycle();
        dr_ready = 0;
        chk("R6", "empty after drains", dr_valid, 0);

        // R10: flush beats same-cycle store and commit
        st_en = 1; st_tag = 5; st_addr = 32'h60; st_data = 32'hEEEE_0005; flush = 1;
        cycle();
        ld(32'h60, 6);
        chk("R10", "store with flush dropped", fwd_hit, 0);
        do_store(6, 32'h61, 32'hFFFF_0006);
        cm_en = 1; cm_tag = 6; flush = 1;
        cycle();
        ld(32'h61, 7);
        chk("R10", "commit with flush ignored", fwd_hit, 0);
        chk("R10", "nothing to drain", dr_valid, 0);

        // random phase against the model
        next_tag = 8;
        for (int n = 0; n < 4000; n++) begin
            int span = 0;
            int osp = -1;
            int ysp = -1;
            for (int k = 0; k < mdl.size(); k++) begin
                int dd = (next_tag - mdl[k].tag) & TMASK;
                if (dd > span) span = dd;
                if (!mdl[k].cmt) begin
                    if (osp < 0 || is_older(mdl[k].tag, mdl[osp].tag)) osp = k;
                    if (ysp < 0 || is_older(mdl[ysp].tag, mdl[k].tag)) ysp = k;
                end
            end
            dr_ready = ($urandom_range(0, 1) == 1);
            if (span < 20 && $urandom_range(0, 9) < 4) begin
                st_en = 1; st_tag = TAG_W'(next_tag);
                st_addr = ADDR_W'($urandom_range(0, 3)); st_data = $urandom;
                next_tag = (next_tag + 1) & TMASK;
            end
            if (osp >= 0 && $urandom_range(0, 3) == 0) begin
                cm_en = 1; cm_tag = TAG_W'(mdl[osp].tag);
            end
            if (ysp >= 0 && ysp != osp && $urandom_range(0, 11) == 0) begin
                ab_en = 1; ab_tag = TAG_W'(mdl[ysp].tag);
            end
            if ($urandom_range(0, 49) == 0) flush = 1;
            ld_addr = ADDR_W'($urandom_range(0, 3));
            ld_tag  = TAG_W'((next_tag - $urandom_range(0, 6)) & TMASK);
            cycle();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule